// File: doc/BRIEF.md
# Security-Banked Interrupt Distributor Register File

This block is the memory-mapped register file of a small interrupt distributor whose bus accesses each carry a security attribute. Every interrupt source has a group bit. Group 0 interrupts are secure and group 1 interrupts are non-secure. Only secure software may move a source between groups. Non-secure software sees the control register in a narrowed layout. It sees only the per-interrupt fields of group 1 sources; every field of a group 0 source reads as zero to it and ignores its writes.

The register file holds a control word with one enable per group, a group bit and an enable bit per source, and one priority byte and one target byte per source. It exports the enables, the group bits and a per-group forwarding qualification mask for the downstream distributor logic. The bus is a single-cycle register port addressed in 32-bit words. Read data is registered and appears in the cycle after the request.

Top module: `sec_dist_regs`

## Requirements
- R1: After reset, both group enables, every group bit (so every source starts in group 0), every enable bit, every priority byte and every target byte are zero.
- R2: A secure access to the control word (word address 0x00) sees the group 0 enable in bit 0 and the group 1 enable in bit 1, for both reads and writes (a write needs strobe lane 0).
- R3: A non-secure read of the control word returns the group 1 enable in bit 0 and zero in every other bit; after a secure write of 0x3 a secure read gives 0x3 and a non-secure read gives 0x1.
- R4: A non-secure write to the control word loads bit 0 into the group 1 enable and leaves the group 0 enable unchanged, whatever bit 1 holds.
- R5: Group words at 0x08+k hold the group bits of sources 32k..32k+31 (bit n is source 32k+n, 1 means group 1). Only secure writes change them, and non-secure reads return zero.
- R6: Set-enable words at 0x10+k are write-1-to-set. A non-secure write can set only group 1 bits. Reads return the enable bits, with group 0 bits forced to zero on a non-secure read.
- R7: Clear-enable words at 0x18+k are write-1-to-clear, with the same access and read rules as R6.
- R8: Forwarding mask bit n for group 0 is high exactly when source n is enabled, in group 0 and the group 0 enable is set; the group 1 mask is the same with group 1.
- R9: Priority words at 0x20+k and target words at 0x40+k hold four sources each, with byte lane n holding source 4k+n. Only the byte lanes whose write strobe is high are written; strobes gate byte lanes in the same way in every register word.
- R10: In priority and target words, bytes of group 0 sources read as zero to non-secure accesses and ignore non-secure writes, while bytes of group 1 sources in the same word are written and read normally.
- R11: Words beyond the implemented source count, and unmapped addresses, read as zero and ignore writes for both security attributes. The last implemented source is fully accessible.
- R12: Read data is valid in the cycle after a read request and is zero in every cycle that follows a cycle with no read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Word address |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte-lane write strobes |
| req_nonsec | input | 1 | 1 = non-secure access |
| rsp_rdata | output | 32 | Registered read data |
| grp0_en | output | 1 | Group 0 enable |
| grp1_en | output | 1 | Group 1 enable |
| irq_enable | output | NUM_IRQ | Per-source enable bits |
| irq_group | output | NUM_IRQ | Per-source group bits |
| fwd_grp0 | output | NUM_IRQ | Group 0 forwarding qualification |
| fwd_grp1 | output | NUM_IRQ | Group 1 forwarding qualification |

## Verification
On every cycle the assertions check that a non-secure access never alters the group 0 enable, a group bit, an enable bit of a group 0 source or a byte of a group 0 source. They also check that a secure control write lands in the banked layout and that idle cycles leave the read data at zero. Only the bench's scenarios can show the values that come back: the narrowed control view, masked reads in words that mix both groups, strobe-selected bytes, forwarding masks that follow enable changes, and the zero reads beyond the last implemented word.

// File: rtl/dist_pkg.sv
package dist_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned LANES  = DATA_W / 8;

    // Word address map
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h00;
    localparam logic [4:0]        GRP_PAGE  = 5'h01;  // 0x08..0x0F
    localparam logic [4:0]        SET_PAGE  = 5'h02;  // 0x10..0x17
    localparam logic [4:0]        CLR_PAGE  = 5'h03;  // 0x18..0x1F
    localparam logic [2:0]        PRIO_PAGE = 3'h1;   // 0x20..0x3F
    localparam logic [2:0]        TARG_PAGE = 3'h2;   // 0x40..0x5F

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CTRL,
        REG_GRP,
        REG_SET,
        REG_CLR,
        REG_PRIO,
        REG_TARG
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [4:0] index;
    } reg_sel_t;

    typedef struct packed {
        logic g1;
        logic g0;
    } grp_enables_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] addr);
        reg_sel_t s;
        s.kind  = REG_NONE;
        s.index = '0;
        if (addr == CTRL_ADDR) begin
            s.kind = REG_CTRL;
        end else if (addr[7:3] == GRP_PAGE) begin
            s.kind  = REG_GRP;
            s.index = {2'b00, addr[2:0]};
        end else if (addr[7:3] == SET_PAGE) begin
            s.kind  = REG_SET;
            s.index = {2'b00, addr[2:0]};
        end else if (addr[7:3] == CLR_PAGE) begin
            s.kind  = REG_CLR;
            s.index = {2'b00, addr[2:0]};
        end else if (addr[7:5] == PRIO_PAGE) begin
            s.kind  = REG_PRIO;
            s.index = addr[4:0];
        end else if (addr[7:5] == TARG_PAGE) begin
            s.kind  = REG_TARG;
            s.index = addr[4:0];
        end
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] strb);
        logic [DATA_W-1:0] m;
        for (int l = 0; l < LANES; l++) begin
            m[l*8 +: 8] = {8{strb[l]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/dist_ctrl.sv
module dist_ctrl
    import dist_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              nonsec,
    input  logic [1:0]        wbits,
    output logic              g0_en,
    output logic              g1_en,
    output logic [DATA_W-1:0] rd_word
);

    grp_enables_t en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (we) begin
            if (nonsec) begin
                en_q.g1 <= wbits[0];
            end else begin
                en_q.g0 <= wbits[0];
                en_q.g1 <= wbits[1];
            end
        end
    end

    assign g0_en = en_q.g0;
    assign g1_en = en_q.g1;

    always_comb begin
        rd_word = '0;
        if (nonsec) begin
            rd_word[0] = en_q.g1;
        end else begin
            rd_word[0] = en_q.g0;
            rd_word[1] = en_q.g1;
        end
    end

    // R4
    ns_keeps_g0_chk: assert property (@(posedge clk) disable iff (rst)
        (we && nonsec) |=> $stable(g0_en));

    // R2
    sec_layout_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !nonsec) |=> (g0_en == $past(wbits[0]) && g1_en == $past(wbits[1])));

endmodule

// File: rtl/dist_bitregs.sv
module dist_bitregs
    import dist_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               grp_we,
    input  logic               set_we,
    input  logic               clr_we,
    input  logic               nonsec,
    input  logic [4:0]         word_idx,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [LANES-1:0]   strb,
    output logic [NUM_IRQ-1:0] group,
    output logic [NUM_IRQ-1:0] enable,
    output logic [DATA_W-1:0]  grp_rd,
    output logic [DATA_W-1:0]  en_rd
);

    localparam int unsigned WORDS = NUM_IRQ / DATA_W;

    logic [WORDS-1:0][DATA_W-1:0] grp_q;
    logic [WORDS-1:0][DATA_W-1:0] en_q;
    logic [DATA_W-1:0] grp_sel, en_sel, reach, smask, hits;

    always_comb begin
        grp_sel = '0;
        en_sel  = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (word_idx == 5'(w)) begin
                grp_sel = grp_q[w];
                en_sel  = en_q[w];
            end
        end
    end

    // Non-secure accesses reach only group 1 bits
    assign reach = nonsec ? grp_sel : '1;
    assign smask = lane_mask(strb);
    assign hits  = wdata & smask & reach;

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q <= '0;
            en_q  <= '0;
        end else begin
            for (int w = 0; w < WORDS; w++) begin
                if (word_idx == 5'(w)) begin
                    if (grp_we && !nonsec) begin
                        grp_q[w] <= (grp_q[w] & ~smask) | (wdata & smask);
                    end
                    if (set_we) begin
                        en_q[w] <= en_q[w] | hits;
                    end else if (clr_we) begin
                        en_q[w] <= en_q[w] & ~hits;
                    end
                end
            end
        end
    end

    assign group  = grp_q;
    assign enable = en_q;
    assign grp_rd = nonsec ? '0 : grp_sel;
    assign en_rd  = en_sel & reach;

    // R5
    ns_group_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (grp_we && nonsec) |=> $stable(group));

    // R6
    ns_secure_enables_kept_chk: assert property (@(posedge clk) disable iff (rst)
        ((set_we || clr_we) && nonsec) |=>
            ((enable & ~group) == ($past(enable) & ~$past(group))));

endmodule

// File: rtl/dist_byte_bank.sv
module dist_byte_bank
    import dist_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic               nonsec,
    input  logic [4:0]         word_idx,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [LANES-1:0]   strb,
    input  logic [NUM_IRQ-1:0] group,
    output logic [DATA_W-1:0]  rd_word
);

    localparam int unsigned IW = $clog2(NUM_IRQ);

    logic [NUM_IRQ-1:0][7:0] byte_q;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        localparam int unsigned WORD = i / LANES;
        localparam int unsigned LANE = i % LANES;

        logic take;
        assign take = we && word_idx == 5'(WORD) && strb[LANE] && (!nonsec || group[i]);

        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q[i] <= '0;
            end else if (take) begin
                byte_q[i] <= wdata[LANE*8 +: 8];
            end
        end

        // R10
        ns_secure_byte_kept_chk: assert property (@(posedge clk) disable iff (rst)
            (we && nonsec && !group[i]) |=> $stable(byte_q[i]));
    end

    always_comb begin
        rd_word = '0;
        for (int l = 0; l < LANES; l++) begin
            int unsigned src;
            src = 32'(word_idx) * LANES + l;
            if (src < NUM_IRQ) begin
                if (!nonsec || group[IW'(src)]) begin
                    rd_word[l*8 +: 8] = byte_q[IW'(src)];
                end
            end
        end
    end

endmodule

// File: rtl/sec_dist_regs.sv
// NUM_IRQ must be a multiple of 32 and at most 128.
module sec_dist_regs
    import dist_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [7:0]         req_addr,
    input  logic [31:0]        req_wdata,
    input  logic [3:0]         req_strb,
    input  logic               req_nonsec,
    output logic [31:0]        rsp_rdata,
    output logic               grp0_en,
    output logic               grp1_en,
    output logic [NUM_IRQ-1:0] irq_enable,
    output logic [NUM_IRQ-1:0] irq_group,
    output logic [NUM_IRQ-1:0] fwd_grp0,
    output logic [NUM_IRQ-1:0] fwd_grp1
);

    localparam int unsigned BIT_WORDS  = NUM_IRQ / DATA_W;
    localparam int unsigned BYTE_WORDS = NUM_IRQ / LANES;

    reg_sel_t          sel;
    logic              in_range, wr, rd;
    logic [DATA_W-1:0] ctrl_rd, grp_rd, en_rd, prio_rd, targ_rd, rd_next;

    assign sel = decode_addr(req_addr);

    always_comb begin
        case (sel.kind)
            REG_CTRL:                 in_range = 1'b1;
            REG_GRP, REG_SET, REG_CLR: in_range = 32'(sel.index) < BIT_WORDS;
            REG_PRIO, REG_TARG:       in_range = 32'(sel.index) < BYTE_WORDS;
            default:                  in_range = 1'b0;
        endcase
    end

    assign wr = req_valid && req_write && in_range;
    assign rd = req_valid && !req_write;

    dist_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .we      (wr && sel.kind == REG_CTRL && req_strb[0]),
        .nonsec  (req_nonsec),
        .wbits   (req_wdata[1:0]),
        .g0_en   (grp0_en),
        .g1_en   (grp1_en),
        .rd_word (ctrl_rd)
    );

    dist_bitregs #(.NUM_IRQ(NUM_IRQ)) u_bits (
        .clk      (clk),
        .rst      (rst),
        .grp_we   (wr && sel.kind == REG_GRP),
        .set_we   (wr && sel.kind == REG_SET),
        .clr_we   (wr && sel.kind == REG_CLR),
        .nonsec   (req_nonsec),
        .word_idx (sel.index),
        .wdata    (req_wdata),
        .strb     (req_strb),
        .group    (irq_group),
        .enable   (irq_enable),
        .grp_rd   (grp_rd),
        .en_rd    (en_rd)
    );

    dist_byte_bank #(.NUM_IRQ(NUM_IRQ)) u_prio (
        .clk      (clk),
        .rst      (rst),
        .we       (wr && sel.kind == REG_PRIO),
        .nonsec   (req_nonsec),
        .word_idx (sel.index),
        .wdata    (req_wdata),
        .strb     (req_strb),
        .group    (irq_group),
        .rd_word  (prio_rd)
    );

    dist_byte_bank #(.NUM_IRQ(NUM_IRQ)) u_targ (
        .clk      (clk),
        .rst      (rst),
        .we       (wr && sel.kind == REG_TARG),
        .nonsec   (req_nonsec),
        .word_idx (sel.index),
        .wdata    (req_wdata),
        .strb     (req_strb),
        .group    (irq_group),
        .rd_word  (targ_rd)
    );

    always_comb begin
        rd_next = '0;
        if (rd && in_range) begin
            case (sel.kind)
                REG_CTRL:         rd_next = ctrl_rd;
                REG_GRP:          rd_next = grp_rd;
                REG_SET, REG_CLR: rd_next = en_rd;
                REG_PRIO:         rd_next = prio_rd;
                REG_TARG:         rd_next = targ_rd;
                default:          rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_rdata <= '0;
        end else begin
            rsp_rdata <= rd_next;
        end
    end

    assign fwd_grp0 = irq_enable & ~irq_group & {NUM_IRQ{grp0_en}};
    assign fwd_grp1 = irq_enable &  irq_group & {NUM_IRQ{grp1_en}};

    // R12
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> (rsp_rdata == '0));

endmodule

// File: tb/test_sec_dist_regs.sv
module test_sec_dist_regs;

    localparam int CLK_PERIOD = 10;
    localparam int N = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [7:0]    req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [3:0]    req_strb = '0;
    logic          req_nonsec = 1'b0;
    logic [31:0]   rsp_rdata;
    logic          grp0_en, grp1_en;
    logic [N-1:0]  irq_enable, irq_group, fwd_grp0, fwd_grp1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_dist_regs #(.NUM_IRQ(N)) i_sec_dist_regs (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_strb   (req_strb),
        .req_nonsec (req_nonsec),
        .rsp_rdata  (rsp_rdata),
        .grp0_en    (grp0_en),
        .grp1_en    (grp1_en),
        .irq_enable (irq_enable),
        .irq_group  (irq_group),
        .fwd_grp0   (fwd_grp0),
        .fwd_grp1   (fwd_grp1)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic ns, input logic [7:0] a, input logic [31:0] d,
                          input logic [3:0] s);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_nonsec = ns;
        req_addr = a; req_wdata = d; req_strb = s;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // Driver: issues a read and queues the expected response
    task automatic bus_rd(input logic ns, input logic [7:0] a, input logic [31:0] exp,
                          input string tag);
        sb_item_t it;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_nonsec = ns;
        req_addr = a; req_wdata = '0; req_strb = '0;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: data appears one cycle after the request was sampled
    initial begin
        forever begin
            @(posedge clk);
            if (!rst && req_valid && !req_write) begin
                #(CLK_PERIOD/4);
                if (sb_q.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R12: read data with no queued expectation, actual %h expected none", rsp_rdata);
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    check(it.tag, {32'd0, rsp_rdata}, {32'd0, it.exp});
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 grp enables", {62'd0, grp1_en, grp0_en}, 64'd0);
        check("R1 groups", irq_group, 64'd0);
        check("R1 enables", irq_enable, 64'd0);
        bus_rd(0, 8'h00, 32'h0, "R1 ctrl");
        bus_rd(0, 8'h20, 32'h0, "R1 prio");
        bus_rd(0, 8'h41, 32'h0, "R1 target");

        // R2 / R3 / R4 control banking
        bus_wr(0, 8'h00, 32'h3, 4'h1);
        check("R12 idle after write", {32'd0, rsp_rdata}, 64'd0);
        bus_rd(0, 8'h00, 32'h3, "R2 secure ctrl");
        bus_rd(1, 8'h00, 32'h1, "R3 nonsecure ctrl");
        bus_wr(1, 8'h00, 32'h2, 4'h1);
        check("R4 g0 kept", {63'd0, grp0_en}, 64'd1);
        check("R4 g1 from bit0", {63'd0, grp1_en}, 64'd0);
        bus_rd(0, 8'h00, 32'h1, "R4 secure view");
        bus_wr(1, 8'h00, 32'h1, 4'h1);
        bus_rd(0, 8'h00, 32'h3, "R4 secure view after ns set");

        // R5 group bits
        bus_wr(1, 8'h08, 32'hFFFF_FFFF, 4'hF);
        check("R5 ns group write ignored", irq_group, 64'd0);
        bus_wr(0, 8'h08, 32'h0000_00F0, 4'hF);
        bus_rd(0, 8'h08, 32'h0000_00F0, "R5 secure group read");
        bus_rd(1, 8'h08, 32'h0, "R5 ns group read");

        // R6 / R7 enables
        bus_wr(1, 8'h10, 32'h0000_00FF, 4'hF);
        check("R6 ns set only group1", irq_enable, 64'hF0);
        bus_rd(0, 8'h10, 32'h0000_00F0, "R6 secure set read");
        bus_wr(0, 8'h10, 32'h0000_000F, 4'hF);
        bus_rd(1, 8'h10, 32'h0000_00F0, "R6 ns masked read");
        bus_wr(1, 8'h18, 32'h0000_00FF, 4'hF);
        bus_rd(0, 8'h18, 32'h0000_000F, "R7 secure clr read");
        bus_rd(1, 8'h18, 32'h0, "R7 ns clr read");

        // R8 forwarding
        check("R8 fwd g0", fwd_grp0, 64'h0F);
        check("R8 fwd g1 none", fwd_grp1, 64'h0);
        bus_wr(0, 8'h10, 32'h0000_0030, 4'hF);
        check("R8 fwd g1", fwd_grp1, 64'h30);
        bus_wr(0, 8'h00, 32'h2, 4'h1);
        check("R8 fwd g0 off", fwd_grp0, 64'h0);
        check("R8 fwd g1 kept", fwd_grp1, 64'h30);
        bus_wr(1, 8'h00, 32'h0, 4'h1);
        check("R8 fwd g1 off", fwd_grp1, 64'h0);
        bus_rd(0, 8'h00, 32'h0, "R8 ctrl both off");

        // R9 / R10 byte fields
        bus_wr(1, 8'h20, 32'hAABB_CCDD, 4'hF);
        bus_rd(0, 8'h20, 32'h0, "R10 ns prio write ignored");
        bus_wr(0, 8'h20, 32'h1122_3344, 4'b0101);
        bus_rd(0, 8'h20, 32'h0022_0044, "R9 strobed prio");
        bus_rd(1, 8'h20, 32'h0, "R10 ns prio read");
        bus_wr(0, 8'h08, 32'h0000_05F0, 4'hF);
        bus_wr(1, 8'h42, 32'hDEAD_BEEF, 4'hF);
        bus_rd(0, 8'h42, 32'h00AD_00EF, "R10 mixed target ns write");
        bus_wr(0, 8'h42, 32'h0000_7700, 4'b0010);
        bus_rd(0, 8'h42, 32'h00AD_77EF, "R9 secure target lane1");
        bus_rd(1, 8'h42, 32'h00AD_00EF, "R10 ns mixed read");

        // R11 range limits
        bus_wr(0, 8'h0A, 32'hFFFF_FFFF, 4'hF);
        bus_rd(0, 8'h0A, 32'h0, "R11 group beyond count");
        check("R11 groups unchanged", irq_group, 64'h5F0);
        bus_wr(0, 8'h12, 32'hFFFF_FFFF, 4'hF);
        bus_rd(0, 8'h12, 32'h0, "R11 enable beyond count");
        check("R11 enables unchanged", irq_enable, 64'h3F);
        bus_wr(0, 8'h30, 32'h1234_5678, 4'hF);
        bus_rd(0, 8'h30, 32'h0, "R11 prio beyond count");
        bus_rd(1, 8'h5F, 32'h0, "R11 target beyond count");
        bus_rd(0, 8'h05, 32'h0, "R11 unmapped");
        bus_wr(0, 8'h2F, 32'hA500_0000, 4'b1000);
        bus_rd(0, 8'h2F, 32'hA500_0000, "R11 last source prio");
        bus_rd(1, 8'h2F, 32'h0, "R10 last source ns");

        repeat (3) @(negedge clk);
        check("R12 idle rdata", {32'd0, rsp_rdata}, 64'd0);
        if (sb_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R12: pending reads actual %0d expected 0", sb_q.size());
        end
        finish_run();
    end

endmodule